// File: doc/BRIEF.md
# Debug Receive Mailbox with Streaming Download

This block is a one-word receive mailbox. An external debugger uses it to hand data words to a debug handler running on the core. The debugger side has a write strobe. Each write carries a data word, a valid qualifier and a download qualifier, and the debugger can see the mailbox's occupancy flag at any time. The core side can read the data word and a 32-bit control/status word that holds the occupancy, download and overflow flags. That word also accepts writes, which the handler uses to acknowledge an overflow.

There are two ways to use the mailbox:

- **Polled use.** Each side waits on the occupancy flag before it acts.
- **Streaming download.** The debugger writes words back to back without polling. The handler loops, reading a word each time the occupancy flag is set, until the debugger drops the download flag. A write that arrives while the previous word is still unread overwrites that word and latches a sticky overflow flag, so the loss is visible to the handler.

Both ports are modelled as single-cycle strobes in one clock domain.

Top module: `dbg_rx_mailbox`

## Requirements
- R1: A debugger write with the valid qualifier high loads the data word into the mailbox and sets the occupancy flag. The new word is visible on the core read data one cycle after the write.
- R2: A handler read returns the word currently held and clears the occupancy flag on the following edge, unless a valid write arrives in the same cycle.
- R3: A valid write with the download qualifier high sets the download flag together with the occupancy flag. A valid write with the download qualifier low leaves the download flag as it was.
- R4: A valid write that arrives while the occupancy flag is set, with no handler read in the same cycle, sets the overflow flag. The new word replaces the held one and the occupancy flag stays set.
- R5: A debugger download-clear strobe clears the download flag. If a valid write with the download qualifier arrives in the same cycle, the flag ends up set.
- R6: A debugger write with the valid qualifier low changes neither the data word nor any flag.
- R7: The overflow flag is sticky. A control/status write with bit 30 set clears it, and a write with bit 30 clear leaves it unchanged. If a new overflow occurs in the same cycle as the clearing write, the flag stays set.
- R8: When a valid write and a handler read occur in the same cycle, the read returns the old word. Afterwards the occupancy flag is set, the new word is held, and no overflow is raised.
- R9: Asserting reset clears the data word and all three flags immediately, without waiting for a clock edge.
- R10: The control/status word has occupancy at bit 31, overflow at bit 30 and download at bit 29, with bits 28 to 0 reading as zero. The debugger's status output equals the occupancy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_wr_i | input | 1 | Debugger write strobe |
| dbg_valid_i | input | 1 | Valid qualifier of the write |
| dbg_dload_i | input | 1 | Download qualifier of the write |
| dbg_wdata_i | input | DATA_W | Data word written by the debugger |
| dbg_dclr_i | input | 1 | Debugger strobe that clears the download flag |
| dbg_ready_o | output | 1 | Occupancy flag as seen by the debugger |
| hdl_rd_i | input | 1 | Handler read strobe for the data word |
| hdl_rdata_o | output | DATA_W | Data word held in the mailbox |
| hdl_csr_wr_i | input | 1 | Handler write strobe for the control/status word |
| hdl_csr_wdata_i | input | 32 | Control/status write data (bit 30 clears overflow when written as 1) |
| hdl_csr_o | output | 32 | Control/status word |

## Verification
The properties assume that the strobes are clean single-cycle levels in the mailbox clock domain. They also assume that nothing is checked until the internally synchronised reset has been released. For this reason they are disabled on the synchronised reset rather than on the raw pin.

The stimulus changes inputs only on the falling clock edge. After every reset, whether at start-up or in the middle of the run, it waits several cycles before the first strobe. It drives every strobe combination deliberately, including the same-cycle collisions of R5, R7 and R8, so that each property's antecedent is reached from a known flag state.

// File: rtl/dbg_rxmb_pkg.sv
package dbg_rxmb_pkg;
  localparam int CSR_W   = 32;
  localparam int RDY_BIT = 31;
  localparam int OVF_BIT = 30;
  localparam int DL_BIT  = 29;

  typedef struct packed {
    logic rdy;
    logic ovf;
    logic dl;
  } rxmb_flags_t;
endpackage

// File: rtl/rxmb_rst_sync.sv
module rxmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/rxmb_data_reg.sv
module rxmb_data_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_d,
  output logic [W-1:0] data_q
);
  logic [W-1:0] data_d;

  always_comb begin
    data_d = load_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/rxmb_flag_ctl.sv
module rxmb_flag_ctl
  import dbg_rxmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ok,
  input  logic        wr_dl,
  input  logic        rd,
  input  logic        dclr,
  input  logic        ovf_clr,
  output rxmb_flags_t flags_q
);
  rxmb_flags_t flags_d;
  logic        flag_en;
  logic        ovf_set;

  always_comb begin
    flags_d = flags_q;
    ovf_set = wr_ok & flags_q.rdy & ~rd;
    flag_en = wr_ok | rd | dclr | ovf_clr;

    if (wr_ok) begin
      flags_d.rdy = 1'b1;
    end else if (rd) begin
      flags_d.rdy = 1'b0;
    end

    if (wr_ok && wr_dl) begin
      flags_d.dl = 1'b1;
    end else if (dclr) begin
      flags_d.dl = 1'b0;
    end

    if (ovf_set) begin
      flags_d.ovf = 1'b1;
    end else if (ovf_clr) begin
      flags_d.ovf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_en) begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/rxmb_csr_pack.sv
module rxmb_csr_pack
  import dbg_rxmb_pkg::*;
(
  input  rxmb_flags_t      flags,
  output logic [CSR_W-1:0] csr
);
  always_comb begin
    csr          = '0;
    csr[RDY_BIT] = flags.rdy;
    csr[OVF_BIT] = flags.ovf;
    csr[DL_BIT]  = flags.dl;
  end
endmodule

// File: rtl/dbg_rx_mailbox.sv
module dbg_rx_mailbox
  import dbg_rxmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_wr_i,
  input  logic              dbg_valid_i,
  input  logic              dbg_dload_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic              dbg_dclr_i,
  output logic              dbg_ready_o,
  input  logic              hdl_rd_i,
  output logic [DATA_W-1:0] hdl_rdata_o,
  input  logic              hdl_csr_wr_i,
  input  logic [CSR_W-1:0]  hdl_csr_wdata_i,
  output logic [CSR_W-1:0]  hdl_csr_o
);
  logic        rst_sync_n;
  logic        wr_ok;
  logic        ovf_clr;
  rxmb_flags_t flags;

  assign wr_ok   = dbg_wr_i & dbg_valid_i;
  assign ovf_clr = hdl_csr_wr_i & hdl_csr_wdata_i[OVF_BIT];

  rxmb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxmb_data_reg #(.W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (wr_ok & rst_sync_n),
    .load_d  (dbg_wdata_i),
    .data_q  (hdl_rdata_o)
  );

  rxmb_flag_ctl u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok & rst_sync_n),
    .wr_dl   (dbg_dload_i),
    .rd      (hdl_rd_i & rst_sync_n),
    .dclr    (dbg_dclr_i & rst_sync_n),
    .ovf_clr (ovf_clr & rst_sync_n),
    .flags_q (flags)
  );

  rxmb_csr_pack u_csr (
    .flags (flags),
    .csr   (hdl_csr_o)
  );

  assign dbg_ready_o = flags.rdy;
endmodule

// File: rtl/rxmb_checker.sv
module rxmb_checker
  import dbg_rxmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_wr_i,
  input logic              dbg_valid_i,
  input logic              dbg_dload_i,
  input logic [DATA_W-1:0] dbg_wdata_i,
  input logic              dbg_dclr_i,
  input logic              dbg_ready_o,
  input logic              hdl_rd_i,
  input logic [DATA_W-1:0] hdl_rdata_o,
  input logic              hdl_csr_wr_i,
  input logic [CSR_W-1:0]  hdl_csr_wdata_i,
  input logic [CSR_W-1:0]  hdl_csr_o
);
  logic wr_ok;
  assign wr_ok = dbg_wr_i & dbg_valid_i;

  AST_WR_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> hdl_csr_o[RDY_BIT]); // R1
  AST_WR_LOADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> hdl_rdata_o == $past(dbg_wdata_i)); // R1
  AST_RD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hdl_rd_i && !wr_ok) |=> !hdl_csr_o[RDY_BIT]); // R2
  AST_DLOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && dbg_dload_i) |=> hdl_csr_o[DL_BIT]); // R3
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hdl_csr_o[RDY_BIT] && !hdl_rd_i) |=> hdl_csr_o[OVF_BIT] && hdl_csr_o[RDY_BIT]); // R4
  AST_DCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_dclr_i && !(wr_ok && dbg_dload_i)) |=> !hdl_csr_o[DL_BIT]); // R5
  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr_i && !dbg_valid_i && !hdl_rd_i && !dbg_dclr_i && !hdl_csr_wr_i)
    |=> $stable(hdl_rdata_o) && $stable(hdl_csr_o)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hdl_csr_o[OVF_BIT] && !(hdl_csr_wr_i && hdl_csr_wdata_i[OVF_BIT])) |=> hdl_csr_o[OVF_BIT]); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdl_csr_o[OVF_BIT] && wr_ok && hdl_rd_i) |=> !hdl_csr_o[OVF_BIT] && hdl_csr_o[RDY_BIT]); // R8
  AST_CSR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_csr_o[DL_BIT-1:0] == '0); // R10
  AST_READY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ready_o == hdl_csr_o[RDY_BIT]); // R10
endmodule

bind dbg_rx_mailbox rxmb_checker #(.DATA_W(DATA_W)) u_rxmb_checker (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .dbg_wr_i        (dbg_wr_i),
  .dbg_valid_i     (dbg_valid_i),
  .dbg_dload_i     (dbg_dload_i),
  .dbg_wdata_i     (dbg_wdata_i),
  .dbg_dclr_i      (dbg_dclr_i),
  .dbg_ready_o     (dbg_ready_o),
  .hdl_rd_i        (hdl_rd_i),
  .hdl_rdata_o     (hdl_rdata_o),
  .hdl_csr_wr_i    (hdl_csr_wr_i),
  .hdl_csr_wdata_i (hdl_csr_wdata_i),
  .hdl_csr_o       (hdl_csr_o)
);

// File: tb/test_dbg_rx_mailbox.sv
module test_dbg_rx_mailbox;
  localparam int DW = 32;

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [31:0] exp_data;
    logic [31:0] exp_csr;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dbg_wr_i = 1'b0;
  logic          dbg_valid_i = 1'b0;
  logic          dbg_dload_i = 1'b0;
  logic [DW-1:0] dbg_wdata_i = '0;
  logic          dbg_dclr_i = 1'b0;
  logic          dbg_ready_o;
  logic          hdl_rd_i = 1'b0;
  logic [DW-1:0] hdl_rdata_o;
  logic          hdl_csr_wr_i = 1'b0;
  logic [31:0]   hdl_csr_wdata_i = '0;
  logic [31:0]   hdl_csr_o;

  sb_item_t    sb_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] m_data = '0;
  logic        m_rdy = 1'b0, m_ov = 1'b0, m_dl = 1'b0;

  always #10 clk = ~clk;

  dbg_rx_mailbox #(.DATA_W(DW)) i_dbg_rx_mailbox (
    .clk(clk), .rst_n(rst_n),
    .dbg_wr_i(dbg_wr_i), .dbg_valid_i(dbg_valid_i), .dbg_dload_i(dbg_dload_i),
    .dbg_wdata_i(dbg_wdata_i), .dbg_dclr_i(dbg_dclr_i), .dbg_ready_o(dbg_ready_o),
    .hdl_rd_i(hdl_rd_i), .hdl_rdata_o(hdl_rdata_o),
    .hdl_csr_wr_i(hdl_csr_wr_i), .hdl_csr_wdata_i(hdl_csr_wdata_i), .hdl_csr_o(hdl_csr_o)
  );

  function automatic logic [31:0] exp_csr();
    return {m_rdy, m_ov, m_dl, 29'b0};
  endfunction

  task automatic push_state(string tag);
    sb_item_t it;
    it.tag = tag; it.is_rd = 1'b0; it.exp_data = m_data; it.exp_csr = exp_csr();
    sb_q.push_back(it);
  endtask

  // Driver: applies one cycle of strobes, predicts the outcome from the requirements
  task automatic step(string tag, bit wr, bit vld, bit dl, logic [31:0] wd,
                      bit rd, bit dclr, bit cwr, logic [31:0] cwd);
    sb_item_t it;
    bit wr_ok, ov_set;
    @(negedge clk);
    dbg_wr_i = wr; dbg_valid_i = vld; dbg_dload_i = dl; dbg_wdata_i = wd;
    hdl_rd_i = rd; dbg_dclr_i = dclr; hdl_csr_wr_i = cwr; hdl_csr_wdata_i = cwd;
    #1;
    if (rd) begin
      it.tag = tag; it.is_rd = 1'b1; it.exp_data = m_data; it.exp_csr = '0;
      sb_q.push_back(it);
    end
    wr_ok  = wr & vld;
    ov_set = wr_ok & m_rdy & !rd;
    if (wr_ok) m_data = wd;
    m_rdy = wr_ok ? 1'b1 : (rd ? 1'b0 : m_rdy);
    m_dl  = (wr_ok & dl) ? 1'b1 : (dclr ? 1'b0 : m_dl);
    m_ov  = ov_set ? 1'b1 : ((cwr & cwd[30]) ? 1'b0 : m_ov);
    @(posedge clk);
    #1;
    push_state(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    dbg_wr_i = 0; dbg_valid_i = 0; dbg_dload_i = 0; hdl_rd_i = 0;
    dbg_dclr_i = 0; hdl_csr_wr_i = 0; hdl_csr_wdata_i = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    #1;
    m_data = '0; m_rdy = 0; m_ov = 0; m_dl = 0;
    push_state("R9");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    sb_item_t it;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      n_chk++;
      if (it.is_rd) begin
        if (hdl_rdata_o !== it.exp_data) begin
          n_fail++;
          $display("FAIL %s read data: actual=%h expected=%h", it.tag, hdl_rdata_o, it.exp_data);
        end
      end else if (hdl_rdata_o !== it.exp_data || hdl_csr_o !== it.exp_csr ||
                   dbg_ready_o !== it.exp_csr[31]) begin
        n_fail++;
        $display("FAIL %s state: actual data=%h csr=%h rdy=%b expected data=%h csr=%h rdy=%b",
                 it.tag, hdl_rdata_o, hdl_csr_o, dbg_ready_o, it.exp_data, it.exp_csr, it.exp_csr[31]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();                                                    // R9, R10
    // Polled use
    step("R1", 1, 1, 0, 32'hA5A5_0001, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R6", 1, 0, 1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 32'h0BAD_0BAD, 0, 0, 0, 0);
    // Streaming download
    step("R3", 1, 1, 1, 32'h1111_2222, 0, 0, 0, 0);
    step("R4", 1, 1, 1, 32'h3333_4444, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 32'h5555_5555, 0, 0, 0, 0);               // ignored while full
    step("R2", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 32'hBFFF_FFFF);               // bit 30 clear: sticky
    step("R7", 0, 0, 0, 0, 0, 0, 1, 32'h4000_0000);               // W1C
    // Streaming loop with handler keeping up
    for (int i = 0; i < 8; i++) begin
      step("R1", 1, 1, 1, 32'hC000_0000 + i, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 1, 0, 0, 0);
    end
    // Collision of write and read
    step("R1", 1, 1, 1, 32'h0000_00D0, 0, 0, 0, 0);
    step("R8", 1, 1, 1, 32'h0000_00E0, 1, 0, 0, 0);
    step("R3", 1, 1, 0, 32'h0000_00F0, 1, 0, 0, 0);               // download flag kept
    step("R5", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R3", 1, 1, 0, 32'h0000_0101, 1, 0, 0, 0);               // stays clear
    step("R5", 1, 1, 1, 32'h0000_0202, 1, 1, 0, 0);               // set wins
    step("R5", 0, 0, 0, 0, 1, 1, 0, 0);
    // Overflow and clear in the same cycle
    step("R4", 1, 1, 0, 32'h0000_0303, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 32'h0000_0404, 0, 0, 1, 32'h4000_0000);   // set wins
    step("R7", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);               // all ones clears
    step("R10", 1, 1, 1, 32'h0000_0505, 0, 0, 1, 32'hFFFF_FFFF);  // overflow + layout
    // Reset in the middle of activity
    do_reset();
    step("R1", 1, 1, 0, 32'h7777_8888, 0, 0, 0, 0);
    idle();
    @(negedge clk);
    wait (sb_q.size() == 0);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule